// File: doc/BRIEF.md
# Serial Host Register Port

This block is the slave end of a four-wire serial control link. A host uses it to read and write a small internal register file. A transfer opens when the host pulls chip select low. The host then shifts in sixteen bits: first a command byte, then a data byte. The command byte holds a direction flag and a six-bit register address. For a write, the data byte comes from the host and is sent to the register file as one write strobe. For a read, the block fetches the addressed register once the command byte is complete and shifts it back out during the data byte.

All logic runs on a system clock. Serial clock, chip select and serial data in are expected to be already synchronous to that clock. The block detects the serial clock edges itself. A static edge-select pin sets the serial clock edge on which read data changes, so the block can match hosts that sample on either edge. Serial data out has an output enable that marks when the line should be driven. Outside that window the pad is meant to be tristated.

Top module: `ser_host_port`

## Requirements
- R1: A frame is the first 16 rising serial clock edges after chip select falls. Each rising edge samples one bit of serial data in, least significant bit first. Bits 0 to 7 form the command byte and bits 8 to 15 form the data byte.
- R2: Command bit 0 is the direction flag: 1 means read and 0 means write.
- R3: The register address is command bits 6 down to 1, with bit 1 as the address LSB. Command bit 7 has no effect on the address, and the address stays stable while read data is driven.
- R4: In a write frame, the write strobe pulses high for exactly one system clock cycle, the cycle after the 16th rising edge is detected. During that cycle the address and write data are valid.
- R5: In a read frame, the addressed register is captured on the 8th rising edge. Its bits are returned LSB first, one bit per data-phase bit. The data byte the host sends during a read is ignored.
- R6: With edge select low, serial data out changes only on rising serial clock edges. Bit 0 appears at the 8th rising edge. With edge select high, it changes only on falling edges, and bit 0 appears at the falling edge after the 8th rising edge.
- R7: The output enable is high only during the data phase of a read frame. It stays low in write frames, and it drops in the cycle after chip select goes high.
- R8: Raising chip select before the 16th rising edge aborts the frame. No write strobe is issued, and the next frame starts again from bit 0.
- R9: Rising edges after the 16th in the same chip-select window are ignored, and no second write strobe is issued.
- R10: While reset is applied and right after it, the write strobe and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| edge_sel_i | input | 1 | Read data launch edge: 1 = falling, 0 = rising |
| sdo_o | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe_o | output | 1 | Output enable for the serial data out pad |
| reg_addr_o | output | ADDR_W | Register address |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data from the addressed register |

## Verification
The bench samples serial data out at the end of both the low and the high phase of every data bit. A design that launches on the wrong edge therefore shows a bit that is one position early or late, or an output enable that is already high after the 8th rising edge in falling-edge mode. Reads and writes pair the same address with different values of command bit 7. A decoder that uses bit 7 would then write one register and read back another. An aborted 12-bit write and a 20-edge write frame check the cases where a careless design would issue a partial write or a second strobe, or would read junk because its bit counter had slipped.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/shp_edge_det.sv
module shp_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/shp_frame_rx.sv
module shp_frame_rx
  import shp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              load_o,
  output logic              shift_o
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int FRAME = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-2:0]  cmd_q;   // command MSB is never stored
  logic [DATA_W-1:0] dat_q;
  logic              we_q;
  logic              is_rd;
  logic              live_rise;

  assign is_rd     = (dir_e'(cmd_q[0]) == DIR_READ);
  assign live_rise = rise_i & ~csn_i & (cnt_q < CNT_W'(FRAME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmd_q <= '0;
      dat_q <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (csn_i) begin
        cnt_q <= '0;
      end else if (live_rise) begin
        cnt_q <= cnt_q + 1'b1;
        for (int i = 0; i < CMD_W - 1; i++)
          if (cnt_q == CNT_W'(i)) cmd_q[i] <= sdi_i;
        for (int i = 0; i < DATA_W; i++)
          if (cnt_q == CNT_W'(CMD_W + i)) dat_q[i] <= sdi_i;
        if (cnt_q == CNT_W'(FRAME - 1) && !is_rd) we_q <= 1'b1;
      end
    end
  end

  assign addr_o  = cmd_q[ADDR_W:1];
  assign wdata_o = dat_q;
  assign we_o    = we_q;
  assign load_o  = live_rise & is_rd & (cnt_q == CNT_W'(CMD_W - 1));
  assign shift_o = live_rise & is_rd & (cnt_q >= CNT_W'(CMD_W))
                 & (cnt_q <= CNT_W'(FRAME - 2));
endmodule

// File: rtl/shp_rd_tx.sv
module shp_rd_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              fall_i,
  input  logic              edge_sel_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sdo_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] sh_q;
  logic              act_q;
  logic              oe_q;
  logic              fout_q;   // falling-edge launch stage

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      act_q  <= 1'b0;
      oe_q   <= 1'b0;
      fout_q <= 1'b0;
    end else begin
      if (load_i)       sh_q <= rdata_i;
      else if (shift_i) sh_q <= {1'b0, sh_q[DATA_W-1:1]};

      if (csn_i)       act_q <= 1'b0;
      else if (load_i) act_q <= 1'b1;

      if (fall_i && act_q && !csn_i) fout_q <= sh_q[0];

      if (csn_i)                                   oe_q <= 1'b0;
      else if (load_i && !edge_sel_i)              oe_q <= 1'b1;
      else if (fall_i && act_q && edge_sel_i)      oe_q <= 1'b1;
    end
  end

  assign oe_o  = oe_q;
  assign sdo_o = oe_q & (edge_sel_i ? fout_q : sh_q[0]);
endmodule

// File: rtl/ser_host_port.sv
module ser_host_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              edge_sel_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic rise, fall, load, shift;

  shp_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  shp_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .csn_i   (csn_i),
    .rise_i  (rise),
    .sdi_i   (sdi_i),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .we_o    (reg_we_o),
    .load_o  (load),
    .shift_o (shift)
  );

  shp_rd_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_i      (csn_i),
    .fall_i     (fall),
    .edge_sel_i (edge_sel_i),
    .load_i     (load),
    .shift_i    (shift),
    .rdata_i    (reg_rdata_i),
    .sdo_o      (sdo_o),
    .oe_o       (sdo_oe_o)
  );
endmodule

// File: rtl/shp_checker.sv
module shp_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              sclk_i,
  input logic              edge_sel_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o
);
  p_we_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !$past(csn_i));

  p_oe_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |=> !sdo_oe_o);

  p_no_drive_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !sdo_oe_o);

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o)) |-> $stable(reg_addr_o));

  p_rise_launch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !edge_sel_i && (sdo_o != $past(sdo_o)))
      |-> ($past(sclk_i) && !$past(sclk_i, 2)));

  p_fall_launch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && edge_sel_i && (sdo_o != $past(sdo_o)))
      |-> (!$past(sclk_i) && $past(sclk_i, 2)));
endmodule

bind ser_host_port shp_checker #(.ADDR_W(ADDR_W)) u_shp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .csn_i      (csn_i),
  .sclk_i     (sclk_i),
  .edge_sel_i (edge_sel_i),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/ser_host_port_bench.sv
module ser_host_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NVEC = 8;
  // vector: [16] edge_sel, [15] command bit 7, [14] read, [13:8] addr, [7:0] data
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 6'd5,  8'h3C},
    {1'b0, 1'b1, 1'b1, 6'd5,  8'h77},
    {1'b1, 1'b1, 1'b0, 6'd63, 8'h81},
    {1'b1, 1'b0, 1'b1, 6'd63, 8'h00},
    {1'b0, 1'b0, 1'b1, 6'd0,  8'hFF},
    {1'b0, 1'b1, 1'b0, 6'd0,  8'hFF},
    {1'b1, 1'b1, 1'b1, 6'd0,  8'h12},
    {1'b1, 1'b0, 1'b1, 6'd42, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0, esel = 1'b0;
  logic sdo, sdo_oe, we;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int total = 0, bad = 0, we_cnt = 0, oe_cnt = 0;
  logic [5:0] last_addr;
  logic [7:0] last_data;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_host_port u_ser_host_port (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .edge_sel_i(esel), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_addr_o(addr),
    .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  assign rdata = mem[addr];

  initial for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'hA5;

  always @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
      we_cnt    <= we_cnt + 1;
      last_addr <= addr;
      last_data <= wdata;
    end
    if (sdo_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic frame(input logic [15:0] word, input int nbits,
                       output logic [7:0] got_lo, output logic [7:0] got_hi,
                       output logic oe8);
    got_lo = '0; got_hi = '0; oe8 = 1'b0;
    csn = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      sdi  = (b < 16) ? word[b] : 1'b1;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (b >= 8 && b < 16) got_lo[b-8] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (b >= 8 && b < 16) got_hi[b-8] = sdo;
      if (b == 7) oe8 = sdo_oe;
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi, ex, ex_hi;
    logic oe8;
    int w0, o0;
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    chk(!we && !sdo_oe, "R10 reset outputs", {we, sdo_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!we && !sdo_oe, "R10 after reset", {we, sdo_oe}, 0);

    for (int v = 0; v < NVEC; v++) begin
      esel = VEC[v][16];
      w0 = we_cnt; o0 = oe_cnt;
      frame({VEC[v][7:0], VEC[v][15], VEC[v][13:8], VEC[v][14]}, 16, lo, hi, oe8);
      if (!VEC[v][14]) begin
        exp_mem[VEC[v][13:8]] = VEC[v][7:0];
        chk(we_cnt - w0 == 1, "R4 one strobe", we_cnt - w0, 1);
        chk(last_addr == VEC[v][13:8], "R3 write addr", last_addr, VEC[v][13:8]);
        chk(last_data == VEC[v][7:0], "R1 write data", last_data, VEC[v][7:0]);
        chk(oe_cnt == o0, "R7 no drive on write", oe_cnt - o0, 0);
      end else begin
        ex = exp_mem[VEC[v][13:8]];
        ex_hi = esel ? ex : {ex[7], ex[7:1]};
        chk(we_cnt == w0, "R2 read has no strobe", we_cnt - w0, 0);
        chk(lo == ex, "R5 read data", lo, ex);
        chk(hi == ex_hi, "R6 launch edge data", hi, ex_hi);
        chk(oe8 == !esel, "R6 enable at 8th rise", oe8, !esel);
        chk(oe_cnt > o0, "R7 drive on read", oe_cnt - o0, 1);
      end
      chk(!sdo_oe, "R7 released after frame", sdo_oe, 0);
    end

    // R8: abort a write to address 5 after 12 bits
    esel = 1'b0;
    w0 = we_cnt;
    frame({8'hE7, 1'b0, 6'd5, 1'b0}, 12, lo, hi, oe8);
    chk(we_cnt == w0, "R8 abort no strobe", we_cnt - w0, 0);
    frame({8'h00, 1'b0, 6'd5, 1'b1}, 16, lo, hi, oe8);
    chk(lo == exp_mem[5], "R8 register unchanged", lo, exp_mem[5]);

    // R9: extra rising edges after a write frame
    w0 = we_cnt;
    frame({8'hC3, 1'b1, 6'd17, 1'b0}, 20, lo, hi, oe8);
    exp_mem[17] = 8'hC3;
    chk(we_cnt - w0 == 1, "R9 single strobe", we_cnt - w0, 1);
    chk(last_data == 8'hC3 && last_addr == 6'd17, "R9 data intact", last_data, 8'hC3);
    esel = 1'b1;
    frame({8'hFF, 1'b0, 6'd17, 1'b1}, 16, lo, hi, oe8);
    chk(lo == 8'hC3, "R9 readback", lo, 8'hC3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule